// File: doc/BRIEF.md
# Low-Speed USB Serial Receiver

This block turns the two line wires of a low-speed USB link into received bytes. Both wires are taken into the system clock domain, which runs at about eleven cycles per bit. The receiver waits on the idle state and hunts for the start pattern. It locks its bit timing to that pattern's J-to-K edges. Then it decodes the NRZI bit stream, drops stuffed bits and assembles bytes least significant bit first. Each finished byte goes out with a one-cycle write strobe and its buffer position, so a plain memory can store it directly.

A single-ended zero seen at a bit sample closes the packet, and the number of whole bytes is reported. A packet longer than the configured buffer is cut off with an overflow pulse. Every line transition reloads the bit timer, so the sample point follows the sender when the two clocks differ by about a percent. A departure from idle that is never followed by a J-to-K edge, such as a keep-alive pulse, is counted as a frame marker rather than treated as a packet.

Top module: `lsusb_rx`

## Requirements
- R1: After reset, byte_valid_o, pkt_done_o and overflow_o are low, and marker_cnt_o and pkt_len_o are zero.
- R2: Line states are coded as {dp_i, dm_i}. J (idle) is 01, K is 10 and SE0 is 00. Both wires pass through a two-flop synchronizer before any decision.
- R3: A J-to-K edge starts a sync check. The packet is accepted only when K is sampled at two consecutive bit centres. A lone K followed by J sends the block back to hunting for the next J-to-K edge, and a packet that follows one bit later is still received with no marker counted.
- R4: NRZI decoding gives 1 when a bit sample equals the previous one and 0 when it differs. The last K of the sync pattern is the first reference.
- R5: Bytes are assembled least significant bit first. Each byte appears on byte_o with byte_valid_o high for one cycle and byte_idx_o equal to its position in the packet, counting from 0.
- R6: After six consecutive decoded ones, the next bit is dropped and is not stored. The final sync bit counts as the first of those ones.
- R7: An SE0 at a bit sample ends the packet. pkt_done_o pulses for one cycle with pkt_len_o equal to the number of whole bytes, which may be 0. Trailing bits that do not form a whole byte are discarded.
- R8: At most BUF_BYTES bytes are written. When byte number BUF_BYTES+1 completes, it is not written. overflow_o pulses instead, no pkt_done_o follows, and the rest of the packet is ignored until SE0.
- R9: Each line transition reloads the bit timer, so the next sample falls half a bit later. Packets are received correctly with a bit period 1% longer or 1% shorter than CYC_PER_BIT cycles.
- R10: A departure from J with no J-to-K edge within HUNT_BITS bit times raises marker_cnt_o by exactly one. No byte is written and pkt_done_o does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, about CYC_PER_BIT cycles per bit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | One-cycle write strobe for byte_o |
| byte_idx_o | output | clog2(BUF_BYTES) | Buffer position of byte_o |
| pkt_done_o | output | 1 | One-cycle pulse at packet end |
| pkt_len_o | output | clog2(BUF_BYTES+1) | Whole bytes received, valid with pkt_done_o |
| overflow_o | output | 1 | One-cycle pulse when the buffer limit is exceeded |
| marker_cnt_o | output | MARK_W | Count of frame-marker events, wraps |

## Verification
A wrong bit-timer phase shows up first as corrupted byte values. This is worst in the vectors run at ±1% rate, because there the drift between transitions builds up over runs of equal bits. A stuck ones counter or bit counter shifts every later byte by one bit position, so the miscompare appears on the first byte after the fault and the length is wrong too. A sync checker or hunt window in the wrong state shows up at the end of the packet instead: as an extra or missing frame-marker count, as a missing pkt_done_o pulse, or as a byte index that does not start at zero.

// File: rtl/lsusb_rx_pkg.sv
package lsusb_rx_pkg;
  // {dp, dm}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_CHECK,
    ST_RECV,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/lsusb_rx_line_sync.sv
module lsusb_rx_line_sync
  import lsusb_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_e line_o,
  output line_e line_prev_o,
  output logic  edge_o
);
  localparam logic [1:0] IdleRaw = LN_J;

  logic [1:0] raw;
  logic [1:0] synced;
  line_e      prev_q;

  assign raw = {dp_i, dm_i};

  for (genvar g = 0; g < 2; g++) begin : g_wire
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {SYNC_STAGES{IdleRaw[g]}};
      else         chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= LN_J;
    else         prev_q <= line_e'(synced);
  end

  assign line_o      = line_e'(synced);
  assign line_prev_o = prev_q;
  assign edge_o      = (line_e'(synced) != prev_q);
endmodule

// File: rtl/lsusb_rx_bit_timer.sv
module lsusb_rx_bit_timer #(
  parameter int CYC_PER_BIT = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic realign_i,
  output logic strobe_o
);
  localparam int CW   = $clog2(CYC_PER_BIT);
  localparam int HALF = CYC_PER_BIT / 2;

  logic [CW-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tick_q <= CW'(CYC_PER_BIT - 1);
    else if (realign_i)       tick_q <= CW'(HALF - 1);
    else if (tick_q == '0)    tick_q <= CW'(CYC_PER_BIT - 1);
    else                      tick_q <= tick_q - 1'b1;
  end

  // an edge landing on a sample slot postpones the sample to the new bit
  assign strobe_o = (tick_q == '0) && !realign_i;

  AST_REALIGN_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_i |=> !strobe_o); // R9
  AST_STROBE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R9
endmodule

// File: rtl/lsusb_rx_destuff.sv
module lsusb_rx_destuff #(
  parameter int STUFF_RUN = 6,
  parameter int BYTE_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              bit_en_i,
  input  logic              level_k_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int BW = $clog2(BYTE_W);

  logic              last_k_q;
  logic [OW-1:0]     ones_q;
  logic [BW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic              dbit;
  logic              stuffed;
  logic [BYTE_W-1:0] sr_n;

  assign dbit        = (level_k_i == last_k_q);
  assign stuffed     = (ones_q == OW'(STUFF_RUN));
  assign sr_n        = {dbit, sr_q[BYTE_W-1:1]};
  assign byte_done_o = bit_en_i && !stuffed && (cnt_q == BW'(BYTE_W - 1));
  assign byte_o      = sr_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_k_q <= 1'b1;
      ones_q   <= '0;
      cnt_q    <= '0;
      sr_q     <= '0;
    end else if (init_i) begin
      // last sync bit is K and decodes as a one
      last_k_q <= 1'b1;
      ones_q   <= OW'(1);
      cnt_q    <= '0;
    end else if (bit_en_i) begin
      last_k_q <= level_k_i;
      if (stuffed) begin
        ones_q <= '0;
      end else begin
        sr_q   <= sr_n;
        cnt_q  <= cnt_q + 1'b1;
        ones_q <= dbit ? ones_q + 1'b1 : '0;
      end
    end
  end

  AST_STUFF_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && stuffed && !init_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
  import lsusb_rx_pkg::*;
#(
  parameter int CYC_PER_BIT = 11,
  parameter int BUF_BYTES   = 8,
  parameter int HUNT_BITS   = 3,
  parameter int MARK_W      = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           dp_i,
  input  logic                           dm_i,
  output logic [7:0]                     byte_o,
  output logic                           byte_valid_o,
  output logic [$clog2(BUF_BYTES)-1:0]   byte_idx_o,
  output logic                           pkt_done_o,
  output logic [$clog2(BUF_BYTES+1)-1:0] pkt_len_o,
  output logic                           overflow_o,
  output logic [MARK_W-1:0]              marker_cnt_o
);
  localparam int IDX_W    = $clog2(BUF_BYTES);
  localparam int LEN_W    = $clog2(BUF_BYTES + 1);
  localparam int HUNT_CYC = HUNT_BITS * CYC_PER_BIT;
  localparam int HW       = $clog2(HUNT_CYC);

  line_e     line, line_prev;
  logic      edge_w, strobe;
  rx_state_e st_q;
  logic      chk2_q;
  logic [HW-1:0]    hunt_q;
  logic [LEN_W-1:0] cnt_q;
  logic      jk_edge, leave_j;
  logic      bit_en, ds_init, byte_done;
  logic [7:0] ds_byte;

  lsusb_rx_line_sync #(.SYNC_STAGES(2)) u_line (
    .clk_i, .rst_ni, .dp_i, .dm_i,
    .line_o(line), .line_prev_o(line_prev), .edge_o(edge_w)
  );

  lsusb_rx_bit_timer #(.CYC_PER_BIT(CYC_PER_BIT)) u_timer (
    .clk_i, .rst_ni, .realign_i(edge_w), .strobe_o(strobe)
  );

  assign jk_edge = (line_prev == LN_J) && (line == LN_K);
  assign leave_j = (line_prev == LN_J) && (line != LN_J);
  assign bit_en  = (st_q == ST_RECV) && strobe && (line != LN_SE0);
  assign ds_init = (st_q == ST_CHECK) && chk2_q && strobe && (line == LN_K);

  lsusb_rx_destuff #(.STUFF_RUN(6), .BYTE_W(8)) u_destuff (
    .clk_i, .rst_ni,
    .init_i(ds_init), .bit_en_i(bit_en), .level_k_i(line == LN_K),
    .byte_done_o(byte_done), .byte_o(ds_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      chk2_q       <= 1'b0;
      hunt_q       <= '0;
      cnt_q        <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      byte_idx_o   <= '0;
      pkt_done_o   <= 1'b0;
      pkt_len_o    <= '0;
      overflow_o   <= 1'b0;
      marker_cnt_o <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      pkt_done_o   <= 1'b0;
      overflow_o   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (jk_edge) begin
            st_q   <= ST_CHECK;
            chk2_q <= 1'b0;
          end else if (leave_j) begin
            st_q   <= ST_HUNT;
            hunt_q <= '0;
          end
        end
        ST_HUNT: begin
          if (jk_edge) begin
            st_q   <= ST_CHECK;
            chk2_q <= 1'b0;
          end else if (hunt_q == HW'(HUNT_CYC - 1)) begin
            st_q         <= ST_IDLE;
            marker_cnt_o <= marker_cnt_o + 1'b1;
          end else begin
            hunt_q <= hunt_q + 1'b1;
          end
        end
        ST_CHECK: begin
          if (strobe) begin
            if (line != LN_K) begin
              st_q   <= ST_HUNT;
              hunt_q <= '0;
            end else if (!chk2_q) begin
              chk2_q <= 1'b1;
            end else begin
              st_q  <= ST_RECV;
              cnt_q <= '0;
            end
          end
        end
        ST_RECV: begin
          if (strobe && line == LN_SE0) begin
            st_q       <= ST_IDLE;
            pkt_done_o <= 1'b1;
            pkt_len_o  <= cnt_q;
          end else if (byte_done) begin
            if (cnt_q == LEN_W'(BUF_BYTES)) begin
              st_q       <= ST_SKIP;
              overflow_o <= 1'b1;
            end else begin
              byte_o       <= ds_byte;
              byte_valid_o <= 1'b1;
              byte_idx_o   <= cnt_q[IDX_W-1:0];
              cnt_q        <= cnt_q + 1'b1;
            end
          end
        end
        ST_SKIP: begin
          if (line == LN_SE0) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_MARKER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(marker_cnt_o) |-> marker_cnt_o == $past(marker_cnt_o) + MARK_W'(1)); // R10
  AST_LEN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> pkt_len_o <= LEN_W'(BUF_BYTES)); // R8
  AST_NO_DONE_AFTER_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |-> !pkt_done_o); // R8
  AST_DONE_ENDS_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |=> !byte_valid_o); // R7
endmodule

// File: tb/lsusb_rx_tb_top.sv
`timescale 1ns/1ps
module lsusb_rx_tb_top;
  localparam int BUF_BYTES = 8;
  localparam logic [1:0] SJ = 2'b01, SK = 2'b10, S0 = 2'b00;
  // {rate, len, data}: rate 0 nominal, 1 slow (+1%), 2 fast (-1%); byte 0 in data[7:0]
  localparam int NV = 7;
  localparam logic [36:0] VEC [NV] = '{
    {2'd0, 3'd1, 32'h0000_00A5},
    {2'd0, 3'd4, 32'h813C_FF00},
    {2'd1, 3'd3, 32'h00FF_FFFF},
    {2'd2, 3'd4, 32'hFF7F_FE7E},
    {2'd0, 3'd0, 32'h0000_0000},
    {2'd2, 3'd2, 32'h0000_3FC3},
    {2'd1, 3'd4, 32'h7856_3412}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b1;
  logic [7:0] byte_w;
  logic       valid_w, done_w, ovf_w;
  logic [2:0] idx_w;
  logic [3:0] len_w;
  logic [7:0] mark_w;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rx_n = 0, done_n = 0, ovf_n = 0, last_len = 0, exp_mark = 0;
  logic [7:0] rx_buf [32];
  int         rx_idx [32];
  logic [7:0] tx_buf [16];

  always #2 clk = ~clk;

  lsusb_rx #(.CYC_PER_BIT(11), .BUF_BYTES(BUF_BYTES), .HUNT_BITS(3), .MARK_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm),
    .byte_o(byte_w), .byte_valid_o(valid_w), .byte_idx_o(idx_w),
    .pkt_done_o(done_w), .pkt_len_o(len_w), .overflow_o(ovf_w), .marker_cnt_o(mark_w)
  );

  always @(negedge clk) begin
    if (valid_w) begin
      if (rx_n < 32) begin
        rx_buf[rx_n] = byte_w;
        rx_idx[rx_n] = int'(idx_w);
      end
      rx_n++;
    end
    if (done_w) begin
      done_n++;
      last_len = int'(len_w);
    end
    if (ovf_w) ovf_n++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] sym, input real ns);
    {dp, dm} = sym;
    #(ns);
  endtask

  task automatic clear_mon();
    @(negedge clk);
    rx_n = 0; done_n = 0; ovf_n = 0; last_len = -1;
  endtask

  task automatic send_pkt(input int n, input real bn, input int xbits);
    logic lk;
    int ones;
    put(SK, bn); put(SJ, bn); put(SK, bn); put(SJ, bn);
    put(SK, bn); put(SJ, bn); put(SK, bn); put(SK, bn);
    lk = 1'b1; ones = 1;
    for (int i = 0; i < n + 1; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic bt;
        if (i == n && b >= xbits) break;
        bt = (i < n) ? tx_buf[i][b] : 1'b0;
        if (bt) ones++;
        else begin lk = ~lk; ones = 0; end
        put(lk ? SK : SJ, bn);
        if (ones == 6) begin
          lk = ~lk; ones = 0;
          put(lk ? SK : SJ, bn);
        end
      end
    end
    put(S0, bn); put(S0, bn); put(SJ, bn * 5.0);
  endtask

  task automatic check_pkt(input string tag, input int n);
    chk({tag, " done count R7"}, done_n, 1);
    chk({tag, " length R7"}, last_len, n);
    chk({tag, " bytes written R5"}, rx_n, n);
    chk({tag, " overflow R8"}, ovf_n, 0);
    for (int i = 0; i < n && i < rx_n; i++) begin
      chk({tag, " byte value R4 R5"}, int'(rx_buf[i]), int'(tx_buf[i]));
      chk({tag, " byte index R5"}, rx_idx[i], i);
    end
    chk({tag, " no marker R3"}, int'(mark_w), exp_mark);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 valid at reset", int'(valid_w), 0);
    chk("R1 done at reset", int'(done_w), 0);
    chk("R1 overflow at reset", int'(ovf_w), 0);
    chk("R1 marker at reset", int'(mark_w), 0);
    chk("R1 length at reset", int'(len_w), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      int len;
      real bn;
      e   = VEC[v];
      len = int'(e[34:32]);
      bn  = (e[36:35] == 2'd1) ? 44.44 : (e[36:35] == 2'd2) ? 43.56 : 44.0;
      for (int i = 0; i < 4; i++) tx_buf[i] = e[8*i +: 8];
      clear_mon();
      send_pkt(len, bn, 0);
      repeat (4) @(negedge clk);
      check_pkt((e[36:35] != 2'd0) ? "R9 R2 rate vector" : "R2 vector", len);
    end

    // R6: long runs of ones force stuffing inside and across bytes
    tx_buf[0] = 8'hFF; tx_buf[1] = 8'hFF; tx_buf[2] = 8'hF8; tx_buf[3] = 8'h1F;
    clear_mon();
    send_pkt(4, 44.0, 0);
    repeat (4) @(negedge clk);
    check_pkt("R6 stuffing", 4);

    // R7: trailing partial byte is discarded
    tx_buf[0] = 8'h5A;
    clear_mon();
    send_pkt(1, 44.0, 3);
    repeat (4) @(negedge clk);
    check_pkt("R7 partial tail", 1);

    // R10: keep-alive pulse
    clear_mon();
    put(S0, 88.0); put(SJ, 44.0 * 6);
    repeat (4) @(negedge clk);
    exp_mark++;
    chk("R10 marker after keep-alive", int'(mark_w), exp_mark);
    chk("R10 no byte after keep-alive", rx_n, 0);
    chk("R10 no done after keep-alive", done_n, 0);

    // R3: lone K then long J -> back to hunting, then marker
    clear_mon();
    put(SK, 44.0); put(SJ, 44.0 * 6);
    repeat (4) @(negedge clk);
    exp_mark++;
    chk("R3 R10 lone K marker", int'(mark_w), exp_mark);
    chk("R3 lone K no done", done_n, 0);

    // R3: lone K, one J, then a packet
    tx_buf[0] = 8'hC7; tx_buf[1] = 8'h20;
    clear_mon();
    put(SK, 44.0); put(SJ, 44.0);
    send_pkt(2, 44.0, 0);
    repeat (4) @(negedge clk);
    check_pkt("R3 false start", 2);

    // R8: one byte over the limit
    for (int i = 0; i < BUF_BYTES + 1; i++) tx_buf[i] = 8'h10 + 8'(i);
    clear_mon();
    send_pkt(BUF_BYTES + 1, 44.0, 0);
    repeat (4) @(negedge clk);
    chk("R8 overflow pulse", ovf_n, 1);
    chk("R8 bytes kept", rx_n, BUF_BYTES);
    chk("R8 no done on overflow", done_n, 0);
    for (int i = 0; i < BUF_BYTES && i < rx_n; i++)
      chk("R8 kept byte value", int'(rx_buf[i]), int'(tx_buf[i]));

    // R8: exactly full buffer is fine
    for (int i = 0; i < BUF_BYTES; i++) tx_buf[i] = 8'hE0 ^ 8'(i * 37);
    clear_mon();
    send_pkt(BUF_BYTES, 43.56, 0);
    repeat (4) @(negedge clk);
    check_pkt("R8 full buffer", BUF_BYTES);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule